// File: doc/BRIEF.md
# Way-Predicted Tag Lookup

This block is the lookup stage of a small set-associative cache. Each set carries a predictor entry naming the way that is expected to hit. The data-select multiplexer is steered from that entry as soon as the registered request is available, so a correct guess does not have to wait for the full tag comparison. In parallel, the tags of every way in the indexed set are checked against the request. When another way holds the line, the response is delayed by one cycle, the predictor entry is corrected, and the data of the matching way is returned.

A request is a word address split into a set index (low bits) and a tag (the remaining high bits). A simple install port writes a tag, a valid bit and a data word into a chosen way of a chosen set. Refill sequencing, stores and victim choice belong to the surrounding cache. Two counters report how many hits were predicted correctly and how many were not.

Top module: `wp_lookup`

## Requirements
- R1: After reset every line is invalid, so every lookup misses. Every predictor entry points at way 0, both counters read zero, no response is driven and `req_ready` is high.
- R2: A request accepted on an edge whose set's predicted way holds a valid matching tag gets a response in the next cycle: `rsp_valid`, `rsp_hit` and `rsp_fast` are high, `rsp_data` holds that way's word, and `req_ready` stays high.
- R3: If a way other than the predicted one matches, the cycle after acceptance shows `rsp_valid` low and `req_ready` low. The cycle after that shows `rsp_valid` and `rsp_hit` high, `rsp_fast` low, and the matching way's data. `req_ready` is low for exactly that one cycle.
- R4: After any hit, the set's predictor entry holds the way that matched. A repeat lookup of the same line is therefore a fast hit.
- R5: If no valid way of the set matches, the cycle after acceptance shows `rsp_valid` and `rsp_miss` high and `rsp_hit` low. The predictor entry is left unchanged.
- R6: A cycle with `fill_en` high writes the tag, data word and valid bit into way `fill_way` of the set addressed by `fill_addr`. Lookups accepted on later edges see the new contents. The caller never places one tag in two ways of a set.
- R7: `pred_good_cnt` rises by one for each fast hit. `pred_bad_cnt` rises by one for each mispredicted hit. Misses change neither counter.
- R8: Requests for correctly predicted lines can be accepted on consecutive edges. Each one is answered in the cycle after its own acceptance.
- R9: The set index is address bits [IDX_W-1:0] and the tag is the bits above it. Two addresses that share a set but differ in the tag never hit on each other's line.
- R10: While `rsp_valid` is high, exactly one of `rsp_hit` and `rsp_miss` is high. `rsp_fast` is only ever high together with `rsp_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Lookup word address |
| req_ready | output | 1 | Request can be accepted this cycle |
| fill_en | input | 1 | Install a line |
| fill_addr | input | ADDR_W | Address of the installed line |
| fill_way | input | $clog2(WAYS) | Way written by the install |
| fill_data | input | DATA_W | Data word of the installed line |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_fast | output | 1 | Hit came from the predicted way |
| rsp_miss | output | 1 | Response is a miss |
| rsp_data | output | DATA_W | Read data |
| pred_good_cnt | output | CNT_W | Correctly predicted hits |
| pred_bad_cnt | output | CNT_W | Mispredicted hits |

## Verification
The bench builds the block with four ways, four sets and a six-bit address. This leaves a four-bit tag, so a small pool of tags gives frequent hits, conflicting tags within a set, and misses. Four ways let the predictor point at a way that is neither the matching one nor way 0, and allow the predicted way to be corrected several times within one set. The narrow address lets random installs and lookups revisit the same sets often enough to exercise predictor drift, tag replacement and back-to-back fast hits.

// File: rtl/wp_lookup.sv
module wp_lookup #(
  parameter int WAYS   = 2,
  parameter int SETS   = 8,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  output logic                      req_ready,
  input  logic                      fill_en,
  input  logic [ADDR_W-1:0]         fill_addr,
  input  logic [$clog2(WAYS)-1:0]   fill_way,
  input  logic [DATA_W-1:0]         fill_data,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic                      rsp_fast,
  output logic                      rsp_miss,
  output logic [DATA_W-1:0]         rsp_data,
  output logic [CNT_W-1:0]          pred_good_cnt,
  output logic [CNT_W-1:0]          pred_bad_cnt
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] data_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAY_W-1:0]  pred_q [SETS];

  logic              s1_v, s2_v;
  logic [ADDR_W-1:0] s1_addr;
  logic [IDX_W-1:0]  s2_set;
  logic [WAY_W-1:0]  s2_way;
  logic [CNT_W-1:0]  good_q, bad_q;

  logic [IDX_W-1:0]  s1_set, f_set;
  logic [TAG_W-1:0]  s1_tag, f_tag;
  logic [WAYS-1:0]   match;
  logic [WAY_W-1:0]  guess, hit_way;
  logic              fast_hit, slow_hit, miss;

  assign s1_set = s1_addr[IDX_W-1:0];
  assign s1_tag = s1_addr[ADDR_W-1:IDX_W];
  assign f_set  = fill_addr[IDX_W-1:0];
  assign f_tag  = fill_addr[ADDR_W-1:IDX_W];
  assign guess  = pred_q[s1_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld_q[s1_set][w] && (tag_q[s1_set][w] == s1_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hit_way = WAY_W'(w);
  end

  assign fast_hit = s1_v && match[guess];
  assign slow_hit = s1_v && (|match) && !match[guess];
  assign miss     = s1_v && !(|match);

  assign req_ready     = !slow_hit;
  assign rsp_valid     = fast_hit || miss || s2_v;
  assign rsp_hit       = fast_hit || s2_v;
  assign rsp_fast      = fast_hit;
  assign rsp_miss      = miss;
  assign rsp_data      = s2_v ? data_q[s2_set][s2_way] : data_q[s1_set][guess];
  assign pred_good_cnt = good_q;
  assign pred_bad_cnt  = bad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_addr <= '0;
      s2_v    <= 1'b0;
      s2_set  <= '0;
      s2_way  <= '0;
      good_q  <= '0;
      bad_q   <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        pred_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          data_q[s][w] <= '0;
        end
      end
    end else begin
      s1_v <= req_valid && req_ready;
      if (req_valid && req_ready) s1_addr <= req_addr;
      s2_v   <= slow_hit;
      s2_set <= s1_set;
      s2_way <= hit_way;
      if (slow_hit) begin
        pred_q[s1_set] <= hit_way;
        bad_q          <= bad_q + CNT_W'(1);
      end
      if (fast_hit) good_q <= good_q + CNT_W'(1);
      if (fill_en) begin
        tag_q[f_set][fill_way]  <= f_tag;
        data_q[f_set][fill_way] <= fill_data;
        vld_q[f_set][fill_way]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wp_lookup_chk.sv
module wp_lookup_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fast,
  input logic             rsp_miss,
  input logic [CNT_W-1:0] pred_good_cnt,
  input logic [CNT_W-1:0] pred_bad_cnt
);
  // R10
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss));
  // R10
  fast_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fast |-> (rsp_hit && rsp_valid));
  // R3
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !rsp_valid);
  // R3
  slow_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (rsp_valid && rsp_hit && !rsp_fast && req_ready));
  // R2
  rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(!req_ready)));
  // R7
  good_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fast |=> (pred_good_cnt == $past(pred_good_cnt) + CNT_W'(1)));
  // R7
  bad_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (pred_bad_cnt == $past(pred_bad_cnt) + CNT_W'(1)));
  // R7
  miss_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |=> ($stable(pred_good_cnt) && $stable(pred_bad_cnt)));
endmodule

bind wp_lookup wp_lookup_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fast(rsp_fast),
  .rsp_miss(rsp_miss), .pred_good_cnt(pred_good_cnt), .pred_bad_cnt(pred_bad_cnt)
);

// File: tb/tb_wp_lookup.sv
module tb_wp_lookup;
  localparam int WAYS = 4, SETS = 4, ADDR_W = 6, DATA_W = 16, CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, fill_en = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0, fill_addr = '0;
  logic [1:0] fill_way = '0;
  logic [DATA_W-1:0] fill_data = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_fast, rsp_miss;
  logic [DATA_W-1:0] rsp_data;
  logic [CNT_W-1:0] pred_good_cnt, pred_bad_cnt;

  int tests = 0, fails = 0;
  int mtag [SETS][WAYS];
  bit mvld [SETS][WAYS];
  logic [DATA_W-1:0] mdat [SETS][WAYS];
  int mpred [SETS];
  int goodc = 0, badc = 0;

  always #5 clk = ~clk;

  wp_lookup #(.WAYS(WAYS), .SETS(SETS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_way(fill_way), .fill_data(fill_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fast(rsp_fast), .rsp_miss(rsp_miss),
    .rsp_data(rsp_data), .pred_good_cnt(pred_good_cnt), .pred_bad_cnt(pred_bad_cnt));

  task automatic chk(string rq, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
    end
  endtask

  function automatic int find_way(int s, int t);
    for (int w = 0; w < WAYS; w++)
      if (mvld[s][w] && mtag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(int s, int t);
    return {4'(t), 2'(s)};
  endfunction

  task automatic do_fill(int s, int w, int t, logic [DATA_W-1:0] d);
    int ex = find_way(s, t);
    if (ex >= 0) w = ex;
    @(negedge clk);
    fill_en = 1'b1; fill_addr = mk_addr(s, t); fill_way = 2'(w); fill_data = d;
    @(negedge clk);
    fill_en = 1'b0;
    mtag[s][w] = t; mvld[s][w] = 1'b1; mdat[s][w] = d;
  endtask

  task automatic do_look(int s, int t);
    int m = find_way(s, t);
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk_addr(s, t);
    @(negedge clk);
    req_valid = 1'b0;
    if (m < 0) begin
      chk("R5 miss valid", 32'(rsp_valid), 1);
      chk("R5 miss flag", 32'(rsp_miss), 1);
      chk("R5 miss hit", 32'(rsp_hit), 0);
    end else if (m == mpred[s]) begin
      chk("R2 fast flags", {29'd0, rsp_valid, rsp_hit, rsp_fast}, 32'h7);
      chk("R2 fast data", 32'(rsp_data), 32'(mdat[s][m]));
      chk("R2 ready", 32'(req_ready), 1);
      goodc++;
    end else begin
      chk("R3 stall", {30'd0, rsp_valid, req_ready}, 0);
      @(negedge clk);
      chk("R3 slow flags", {29'd0, rsp_valid, rsp_hit, rsp_fast}, 32'h6);
      chk("R3 slow data", 32'(rsp_data), 32'(mdat[s][m]));
      mpred[s] = m;
      badc++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=running exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < SETS; s++) begin
      mpred[s] = 0;
      for (int w = 0; w < WAYS; w++) mvld[s][w] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 req_ready", 32'(req_ready), 1);
    chk("R1 counters", {pred_good_cnt, pred_bad_cnt}, 0);
    for (int s = 0; s < SETS; s++) do_look(s, 0);   // R1 every line invalid
    // R1 predictor starts at way 0; R6 install visible
    do_fill(0, 0, 1, 16'hA001);
    do_look(0, 1);
    // R3 mispredict, R4 correction
    do_fill(1, 2, 3, 16'hB123);
    do_look(1, 3);
    do_look(1, 3);
    // R9 same set, other tag misses; R5 predictor unchanged
    do_look(1, 5);
    do_look(1, 3);
    // R6 overwrite data of an installed line
    do_fill(1, 2, 3, 16'hC0DE);
    do_look(1, 3);
    // R8 back-to-back fast hits
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk_addr(0, 1);
    @(negedge clk);
    req_addr = mk_addr(1, 3);
    chk("R8 first fast", {29'd0, rsp_valid, rsp_fast, req_ready}, 32'h7);
    chk("R8 first data", 32'(rsp_data), 32'hA001);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 second fast", {30'd0, rsp_valid, rsp_fast}, 32'h3);
    chk("R8 second data", 32'(rsp_data), 32'hC0DE);
    goodc += 2;
    // random mix
    for (int i = 0; i < 600; i++) begin
      int s = int'($urandom % SETS);
      int t = int'($urandom % 6);
      if ($urandom % 4 == 0) do_fill(s, int'($urandom % WAYS), t, 16'($urandom));
      else do_look(s, t);
    end
    @(negedge clk);
    // R7 counters
    chk("R7 good count", 32'(pred_good_cnt), 32'(goodc));
    chk("R7 bad count", 32'(pred_bad_cnt), 32'(badc));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule